// File: doc/BRIEF.md
# Flash Word-Program Command Sequencer

This block drives the write side of an asynchronous, strobe-based flash bus. A host asks it for one operation at a time. It can program one word, enter the shortened-programming mode, or leave that mode. The block turns each request into the matching series of bus write cycles. Every write cycle takes a fixed number of clock cycles with write-enable low, followed by a fixed recovery time.

A standard word program needs two unlock writes, a program-setup write and the final address/data write. Once the shortened mode is active, the program needs only the setup write and the address/data write. An accelerate input gives the same short program without any entry command. The block samples the mode once, when it accepts a request. After reset the block is idle, the bus is released and the shortened mode is off.

Top module: `flash_prog_seq`

## Requirements
- R1: While a write pulse is active (flWeN = 0), flCeN is 0 and flOeN is 1. While busy is low, flWeN and flCeN are both 1. flOeN is 1 at all times.
- R2: With reqOp = 2'b00 (program), accelIn = 0 and the shortened mode off, the block issues exactly four writes in this order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), (reqAddr, reqData).
- R3: With reqOp = 2'b00 and the shortened mode on, the block issues exactly two writes: (0x555, 0xA0), then (reqAddr, reqData).
- R4: reqOp = 2'b01 (enter) issues (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x20). It turns bypassActive on once the last write has finished.
- R5: reqOp = 2'b10 (exit) issues (0x555, 0x90), then (0x000, 0x00). It clears bypassActive once the last write has finished, whatever the mode was before.
- R6: A program accepted with accelIn = 1 uses the two-write sequence of R3 and leaves bypassActive unchanged.
- R7: The block fixes the mode of a program at acceptance. If accelIn changes after acceptance, the number and content of the writes stay the same.
- R8: Each write holds flWeN low for WE_LOW clock cycles. Between writes of one sequence, flWeN is high for WE_HIGH cycles. flAddr and flData do not change while flWeN is low.
- R9: A request is accepted only when busy is low. busy then stays high for N*(WE_LOW+WE_HIGH) cycles, where N is the number of writes. Requests presented while busy is high are ignored.
- R10: After reset the block is idle: busy = 0, bypassActive = 0, flWeN = flCeN = flOeN = 1.
- R11: reqOp = 2'b11 is reserved. The block never accepts it, so no write occurs and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqOp | input | 2 | 00 program, 01 enter short mode, 10 exit short mode, 11 reserved |
| reqAddr | input | ADDR_W | Word address to program |
| reqData | input | DATA_W | Data word to program |
| accelIn | input | 1 | Forces the short program sequence when high at acceptance |
| busy | output | 1 | High from acceptance until the last write recovery ends |
| bypassActive | output | 1 | Short program mode entered by command |
| flAddr | output | ADDR_W | Flash address bus |
| flData | output | DATA_W | Flash data bus (write direction) |
| flCeN | output | 1 | Flash chip enable, active low |
| flOeN | output | 1 | Flash output enable, active low |
| flWeN | output | 1 | Flash write enable, active low |

## Verification
The assertions assume that the host applies reset before any request and drives reqOp from its four defined codes. They also assume the host does not depend on requests made while busy. The bench changes inputs only on falling clock edges, so every request is seen whole at one rising edge. It also moves accelIn around acceptance to test the sampled-mode rule. The bench issues extra requests during busy on purpose, to show that the block drops them rather than relying on the host to avoid them.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_ENTER = 2'b01,
    OP_EXIT  = 2'b10,
    OP_RSVD  = 2'b11
  } fpsOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch request and mode, restart step index
    logic stepNext;  // move to the next write of the sequence
    logic weLow;     // write pulse active this cycle
    logic seqDone;   // last recovery finished, apply mode effect
  } fpsStrb_t;

  localparam int unsigned MAX_STEPS = 4;
  localparam int unsigned STEP_W    = $clog2(MAX_STEPS);

endpackage

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int unsigned WE_LOW  = 3,
  parameter int unsigned WE_HIGH = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  fpsOp_e   reqOp,
  input  logic     lastStep,
  output logic     busy,
  output fpsStrb_t strb
);

  localparam int unsigned MAX_T = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int unsigned TMR_W = (MAX_T > 1) ? $clog2(MAX_T) : 1;
  localparam logic [TMR_W-1:0] LOW_LOAD  = TMR_W'(WE_LOW - 1);
  localparam logic [TMR_W-1:0] HIGH_LOAD = TMR_W'(WE_HIGH - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_e;

  state_e           state, stateNext;
  logic [TMR_W-1:0] timer, timerNext;
  logic             accept;

  assign accept = reqValid && (state == S_IDLE) && (reqOp != OP_RSVD);
  assign busy   = (state != S_IDLE);

  always_comb begin
    stateNext     = state;
    timerNext     = timer;
    strb          = '0;
    strb.weLow    = (state == S_LOW);
    unique case (state)
      S_IDLE: begin
        if (accept) begin
          stateNext = S_LOW;
          timerNext = LOW_LOAD;
          strb.load = 1'b1;
        end
      end
      S_LOW: begin
        if (timer == '0) begin
          stateNext = S_HIGH;
          timerNext = HIGH_LOAD;
        end else begin
          timerNext = timer - 1'b1;
        end
      end
      S_HIGH: begin
        if (timer == '0) begin
          if (lastStep) begin
            stateNext    = S_IDLE;
            strb.seqDone = 1'b1;
          end else begin
            stateNext     = S_LOW;
            timerNext     = LOW_LOAD;
            strb.stepNext = 1'b1;
          end
        end else begin
          timerNext = timer - 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      timer <= '0;
    end else begin
      state <= stateNext;
      timer <= timerNext;
    end
  end

  // R11: reserved code never starts a sequence
  a_r11_rsvd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqOp == OP_RSVD) |=> !busy);

  // R9: a sequence only ends on the datapath's last step
  a_r9_done_on_last: assert property (@(posedge clk) disable iff (!rstN)
    strb.seqDone |-> lastStep);

endmodule

// File: rtl/fps_dpath.sv
module fps_dpath
  import fps_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpsStrb_t          strb,
  input  logic              busyIn,
  input  fpsOp_e            reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              accelIn,
  output logic              lastStep,
  output logic              bypassActive,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busData
);

  localparam logic [ADDR_W-1:0] ADR_KEY1 = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADR_KEY2 = ADDR_W'(12'h2AA);
  localparam logic [ADDR_W-1:0] ADR_ZERO = '0;
  localparam logic [DATA_W-1:0] D_KEY1   = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] D_KEY2   = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] D_SETUP  = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] D_ENTER  = DATA_W'(8'h20);
  localparam logic [DATA_W-1:0] D_EXIT1  = DATA_W'(8'h90);
  localparam logic [DATA_W-1:0] D_EXIT2  = '0;

  fpsOp_e            opQ;
  logic              fastQ;
  logic              bypassQ;
  logic [STEP_W-1:0] stepQ;
  logic [STEP_W-1:0] lastIdx;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ     <= OP_PROG;
      fastQ   <= 1'b0;
      bypassQ <= 1'b0;
      stepQ   <= '0;
      addrQ   <= '0;
      dataQ   <= '0;
    end else begin
      if (strb.load) begin
        opQ   <= reqOp;
        fastQ <= bypassQ | accelIn;
        addrQ <= reqAddr;
        dataQ <= reqData;
        stepQ <= '0;
      end else if (strb.stepNext) begin
        stepQ <= stepQ + 1'b1;
      end
      if (strb.seqDone) begin
        if (opQ == OP_ENTER)     bypassQ <= 1'b1;
        else if (opQ == OP_EXIT) bypassQ <= 1'b0;
      end
    end
  end

  // sequence length per latched operation and mode
  always_comb begin
    unique case (opQ)
      OP_PROG:  lastIdx = fastQ ? STEP_W'(1) : STEP_W'(3);
      OP_ENTER: lastIdx = STEP_W'(2);
      default:  lastIdx = STEP_W'(1);
    endcase
  end
  assign lastStep = (stepQ == lastIdx);

  // address/data of the current write
  always_comb begin
    busAddr = ADR_KEY1;
    busData = D_KEY1;
    unique case (opQ)
      OP_PROG: begin
        if (fastQ) begin
          if (stepQ == '0) begin busAddr = ADR_KEY1; busData = D_SETUP; end
          else             begin busAddr = addrQ;    busData = dataQ;   end
        end else begin
          case (stepQ)
            STEP_W'(0): begin busAddr = ADR_KEY1; busData = D_KEY1;  end
            STEP_W'(1): begin busAddr = ADR_KEY2; busData = D_KEY2;  end
            STEP_W'(2): begin busAddr = ADR_KEY1; busData = D_SETUP; end
            default:    begin busAddr = addrQ;    busData = dataQ;   end
          endcase
        end
      end
      OP_ENTER: begin
        case (stepQ)
          STEP_W'(0): begin busAddr = ADR_KEY1; busData = D_KEY1;  end
          STEP_W'(1): begin busAddr = ADR_KEY2; busData = D_KEY2;  end
          default:    begin busAddr = ADR_KEY1; busData = D_ENTER; end
        endcase
      end
      default: begin
        if (stepQ == '0) begin busAddr = ADR_KEY1; busData = D_EXIT1; end
        else             begin busAddr = ADR_ZERO; busData = D_EXIT2; end
      end
    endcase
  end

  assign bypassActive = bypassQ;

  // R8: bus content frozen across a write pulse
  a_r8_bus_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strb.weLow && $past(strb.weLow)) |-> ($stable(busAddr) && $stable(busData)));

  // R7: the sampled mode does not move during a sequence
  a_r7_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (busyIn && $past(busyIn) && !$past(strb.load)) |-> $stable(fastQ));

  // R2: the step index never passes the sequence end while busy
  a_r2_step_bound: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |-> (stepQ <= lastIdx));

  // R4: short mode only turns on after an enter sequence
  a_r4_enter_sets: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bypassQ) |-> ($past(opQ) == OP_ENTER));

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int unsigned ADDR_W  = 21,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned WE_LOW  = 3,
  parameter int unsigned WE_HIGH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              accelIn,
  output logic              busy,
  output logic              bypassActive,
  output logic [ADDR_W-1:0] flAddr,
  output logic [DATA_W-1:0] flData,
  output logic              flCeN,
  output logic              flOeN,
  output logic              flWeN
);

  fpsStrb_t strb;
  logic     lastStep;
  fpsOp_e   opIn;

  assign opIn = fpsOp_e'(reqOp);

  fps_ctrl #(.WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (opIn),
    .lastStep (lastStep),
    .busy     (busy),
    .strb     (strb)
  );

  fps_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busyIn       (busy),
    .reqOp        (opIn),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .accelIn      (accelIn),
    .lastStep     (lastStep),
    .bypassActive (bypassActive),
    .busAddr      (flAddr),
    .busData      (flData)
  );

  assign flWeN = ~strb.weLow;
  assign flCeN = ~strb.weLow;
  assign flOeN = 1'b1;

endmodule

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;

  localparam int unsigned AW = 21;
  localparam int unsigned DW = 16;
  localparam int unsigned WL = 3;
  localparam int unsigned WH = 2;
  localparam int unsigned PER = WL + WH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = 2'b00;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic accelIn = 1'b0;
  logic busy, bypassActive, flCeN, flOeN, flWeN;
  logic [AW-1:0] flAddr;
  logic [DW-1:0] flData;

  always #4 clk = ~clk;  // 125 MHz

  flash_prog_seq #(.ADDR_W(AW), .DATA_W(DW), .WE_LOW(WL), .WE_HIGH(WH)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .accelIn(accelIn),
    .busy(busy), .bypassActive(bypassActive), .flAddr(flAddr),
    .flData(flData), .flCeN(flCeN), .flOeN(flOeN), .flWeN(flWeN)
  );

  int checks = 0;
  int errors = 0;

  // monitor state
  int nWr = 0;
  logic [AW-1:0] wAddr [8];
  logic [DW-1:0] wData [8];
  int busyCnt = 0;
  int protoErr = 0;
  int timeErr = 0;
  int stabErr = 0;
  int lowLen = 0;
  int highLen = 0;
  logic prevWe = 1'b1;

  always @(negedge clk) begin
    if (!flWeN && (flCeN !== 1'b0)) protoErr++;
    if (flOeN !== 1'b1) protoErr++;
    if (!busy && (flWeN !== 1'b1 || flCeN !== 1'b1)) protoErr++;
    if (busy) busyCnt++;
    if (!flWeN) begin
      if (prevWe) begin
        if (nWr > 0 && highLen != WH) timeErr++;
        if (nWr < 8) begin
          wAddr[nWr] = flAddr;
          wData[nWr] = flData;
        end
        nWr++;
        lowLen = 1;
      end else begin
        lowLen++;
        if (nWr <= 8 && (flAddr !== wAddr[nWr-1] || flData !== wData[nWr-1])) stabErr++;
      end
      highLen = 0;
    end else begin
      if (!prevWe && lowLen != WL) timeErr++;
      if (busy) highLen++;
    end
    prevWe = flWeN;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected write i of an operation, taken from R2..R5
  function automatic logic [AW+DW-1:0] expWrite(input logic [1:0] op, input logic fast,
      input int i, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    ea = '0; ed = '0;
    case (op)
      2'b00: begin
        if (fast) begin
          if (i == 0) begin ea = AW'('h555); ed = DW'('hA0); end
          else begin ea = a; ed = d; end
        end else begin
          case (i)
            0: begin ea = AW'('h555); ed = DW'('hAA); end
            1: begin ea = AW'('h2AA); ed = DW'('h55); end
            2: begin ea = AW'('h555); ed = DW'('hA0); end
            default: begin ea = a; ed = d; end
          endcase
        end
      end
      2'b01: begin
        case (i)
          0: begin ea = AW'('h555); ed = DW'('hAA); end
          1: begin ea = AW'('h2AA); ed = DW'('h55); end
          default: begin ea = AW'('h555); ed = DW'('h20); end
        endcase
      end
      default: begin
        if (i == 0) begin ea = AW'('h555); ed = DW'('h90); end
        else begin ea = '0; ed = '0; end
      end
    endcase
    return {ea, ed};
  endfunction

  task automatic issue(input logic [1:0] op, input logic acc, input logic flip,
      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    nWr = 0; busyCnt = 0;
    reqOp = op; reqAddr = a; reqData = d; accelIn = acc; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (flip) accelIn = ~acc;
  endtask

  task automatic finishOp();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    accelIn = 1'b0;
  endtask

  task automatic verifyOp(input string req, input logic [1:0] op, input logic fast,
      input logic [AW-1:0] a, input logic [DW-1:0] d, input int expN, input logic expByp);
    check(req, "write count", nWr, expN);
    check("R9", "busy length", busyCnt, expN * PER);
    check(req, "bypassActive", bypassActive, expByp);
    for (int i = 0; i < expN && i < nWr && i < 8; i++)
      check(req, $sformatf("write %0d addr/data", i), {wAddr[i], wData[i]}, expWrite(op, fast, i, a, d));
  endtask

  typedef struct packed {
    logic [1:0]    op;
    logic          acc;
    logic          flip;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          fast;
    logic          expByp;
    logic [2:0]    expN;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{2'b00, 1'b0, 1'b0, 21'h12345,  16'hBEEF, 1'b0, 1'b0, 3'd4}, // R2
    '{2'b01, 1'b0, 1'b0, 21'h0,      16'h0,    1'b0, 1'b1, 3'd3}, // R4
    '{2'b00, 1'b0, 1'b0, 21'h1FFFFF, 16'h0001, 1'b1, 1'b1, 3'd2}, // R3
    '{2'b10, 1'b0, 1'b0, 21'h0,      16'h0,    1'b0, 1'b0, 3'd2}, // R5
    '{2'b00, 1'b1, 1'b0, 21'h00ABC,  16'h5A5A, 1'b1, 1'b0, 3'd2}, // R6
    '{2'b00, 1'b1, 1'b1, 21'h0F0F0,  16'h1234, 1'b1, 1'b0, 3'd2}, // R7 accel drops
    '{2'b00, 1'b0, 1'b1, 21'h00555,  16'h00AA, 1'b0, 1'b0, 3'd4}, // R7 accel rises
    '{2'b11, 1'b0, 1'b0, 21'h00001,  16'hFFFF, 1'b0, 1'b0, 3'd0}, // R11
    '{2'b10, 1'b0, 1'b0, 21'h0,      16'h0,    1'b0, 1'b0, 3'd2}, // R5 from standard mode
    '{2'b01, 1'b1, 1'b0, 21'h0,      16'h0,    1'b0, 1'b1, 3'd3}, // R4 with accel high
    '{2'b00, 1'b0, 1'b0, 21'h0,      16'hFFFF, 1'b1, 1'b1, 3'd2}  // R3
  };

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "busy", busy, 0);
    check("R10", "bypassActive", bypassActive, 0);
    check("R10", "strobes", {flWeN, flCeN, flOeN}, 3'b111);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 11; v++) begin
      issue(VECS[v].op, VECS[v].acc, VECS[v].flip, VECS[v].addr, VECS[v].data);
      finishOp();
      verifyOp($sformatf("R%0d", (VECS[v].op == 2'b11) ? 11 :
                                 (VECS[v].op == 2'b01) ? 4 :
                                 (VECS[v].op == 2'b10) ? 5 :
                                 VECS[v].flip ? 7 : VECS[v].acc ? 6 :
                                 VECS[v].fast ? 3 : 2),
               VECS[v].op, VECS[v].fast, VECS[v].addr, VECS[v].data,
               int'(VECS[v].expN), VECS[v].expByp);
    end

    // R9: requests during busy are dropped (leave short mode first)
    issue(2'b10, 1'b0, 1'b0, '0, '0);
    finishOp();
    issue(2'b00, 1'b0, 1'b0, 21'h0CAFE, 16'hD00D);
    reqOp = 2'b01; reqValid = 1'b1;
    repeat (4) @(negedge clk);
    reqValid = 1'b0;
    finishOp();
    verifyOp("R9", 2'b00, 1'b0, 21'h0CAFE, 16'hD00D, 4, 1'b0);

    // R10: reset clears short mode
    issue(2'b01, 1'b0, 1'b0, '0, '0);
    finishOp();
    check("R4", "bypassActive before reset", bypassActive, 1);
    rstN = 1'b0;
    @(negedge clk);
    check("R10", "bypassActive after reset", bypassActive, 0);
    check("R10", "busy after reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    issue(2'b00, 1'b0, 1'b0, 21'h00777, 16'h4321);
    finishOp();
    verifyOp("R10", 2'b00, 1'b0, 21'h00777, 16'h4321, 4, 1'b0);

    check("R1", "strobe protocol violations", protoErr, 0);
    check("R8", "pulse timing violations", timeErr, 0);
    check("R8", "bus changes during pulse", stabErr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule